// File: doc/BRIEF.md
# Serial Port Sample FIFO Interface

This block stands between a 32-bit register bus and a serial shifter. It holds two independent sample queues: one carries words toward the peripheral and the other carries words coming back from it. Both share a single bus location. A bus write always pushes the outbound queue and a bus read always pops the inbound queue. Each access moves exactly one 32-bit entry, and each entry holds one sample.

Samples are right-justified with the sample LSB at bit 0. A programmable size field sets the sample length. Inbound words are stored with zeros above the sample MSB. Outbound bits above the sample MSB are don't-care and are forced to zero before the word reaches the shifter.

Each direction has a threshold condition. It can raise an interrupt request, a DMA request, or both, and each of these outputs has its own enable. The two thresholds use different rules: the inbound request fires when the level is strictly above its threshold, and the outbound request fires when the level is at most its threshold plus one. The shifter side uses a plain valid/ready word handshake in each direction. The block also reports both levels and two sticky error flags, and it has a synchronous flush.

Top module: `sp_fifo_if`

## Requirements
- R1: After reset both levels read 0, both sticky flags are clear, tx_valid_o is low, rx_trig_o is low and tx_trig_o is high.
- R2: A bus write to a transmit queue that is not full stores one entry. Entries are handed to the shifter in write order on tx_data_o. tx_valid_o is high whenever the queue is not empty, and an entry is removed on a cycle with tx_valid_o and tx_ready_i both high.
- R3: A word offered with rx_valid_i while rx_ready_o is high is stored. Bus reads return the stored words in arrival order: bus_rdata_o shows the oldest entry, and bus_rd_i removes it at the clock edge.
- R4: The sample length is dsize_i+1 bits, and any dsize_i below 3 is treated as 3 (4 bits). tx_data_o carries zeros in every bit at or above the sample length.
- R5: Inbound words are stored with zeros in every bit at or above the sample length that is in force when they arrive.
- R6: rx_trig_o is high exactly when rx_level_o > rx_thr_i. rx_irq_o equals rx_trig_o AND rx_irq_en_i, and rx_dma_o equals rx_trig_o AND rx_dma_en_i.
- R7: tx_trig_o is high exactly when tx_level_o <= tx_thr_i+1. tx_irq_o equals tx_trig_o AND tx_irq_en_i, and tx_dma_o equals tx_trig_o AND tx_dma_en_i.
- R8: A bus write while tx_level_o is 16 is dropped and sets tx_ovr_o on the next edge. The flag holds until an ovr_clr_i pulse, and a new overrun in the same cycle wins over the clear.
- R9: A bus read while rx_level_o is 0 returns zero and sets rx_unr_o on the next edge. The flag holds until an unr_clr_i pulse, and a new underrun in the same cycle wins over the clear.
- R10: flush_i empties both queues at the next edge, and it takes priority over a push or pop in the same cycle.
- R11: Each queue holds 16 entries. rx_ready_o is low while the receive queue is full, and an offered word is then not stored.
- R12: rx_level_o and tx_level_o report the current entry counts from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Synchronous clear of both queues |
| dsize_i | input | 5 | Sample length minus one |
| rx_thr_i | input | 4 | Receive threshold |
| tx_thr_i | input | 4 | Transmit threshold |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| rx_dma_en_i | input | 1 | Receive DMA request enable |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| tx_dma_en_i | input | 1 | Transmit DMA request enable |
| ovr_clr_i | input | 1 | Clear pulse for the overrun flag |
| unr_clr_i | input | 1 | Clear pulse for the underrun flag |
| bus_wr_i | input | 1 | Bus write strobe, pushes the transmit queue |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rd_i | input | 1 | Bus read strobe, pops the receive queue |
| bus_rdata_o | output | 32 | Oldest receive entry, or zero when empty |
| tx_valid_o | output | 1 | Transmit word available to the shifter |
| tx_ready_i | input | 1 | Shifter takes the transmit word |
| tx_data_o | output | 32 | Masked transmit word |
| rx_valid_i | input | 1 | Shifter offers a received word |
| rx_ready_o | output | 1 | Receive queue can accept a word |
| rx_data_i | input | 32 | Received word from the shifter |
| rx_level_o | output | 5 | Receive entry count |
| tx_level_o | output | 5 | Transmit entry count |
| rx_trig_o | output | 1 | Raw receive threshold condition |
| tx_trig_o | output | 1 | Raw transmit threshold condition |
| rx_irq_o | output | 1 | Receive interrupt request |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| tx_dma_o | output | 1 | Transmit DMA request |
| tx_ovr_o | output | 1 | Sticky transmit overrun flag |
| rx_unr_o | output | 1 | Sticky receive underrun flag |

## Verification
The bench sets each threshold so that the request flips exactly between two adjacent levels, one level on each side. A design that used the same comparison for both directions, or that left out the plus-one on the transmit side, would fire one level early or late. It fills each queue to 16 and then offers a 17th word. A design with the wrong full condition would overwrite the oldest entry, which the scoreboard catches as a wrong word order, or it would miss the overrun flag. Size codes 0, 2, 3, 4, 7, 11 and 31 are used, so a design without the 4-bit floor or with an off-by-one mask would leak or lose the top bit. A flush issued together with a write checks that no entry survives it.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_MIN_BITS = 4;

  typedef struct packed {
    logic irq;
    logic dma;
  } svc_req_t;
endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LV = LW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  assign full_o  = (level_q == FULL_LV);
  assign empty_o = (level_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/sp_size_mask.sv
module sp_size_mask #(
  parameter int unsigned DW   = 32,
  parameter int unsigned SZ_W = $clog2(DW)
) (
  input  logic [SZ_W-1:0] size_i,
  output logic [DW-1:0]   mask_o
);
  import sp_pkg::*;
  localparam logic [SZ_W-1:0] FLOOR = SZ_W'(SP_MIN_BITS - 1);

  logic [SZ_W-1:0] msb;
  assign msb = (size_i < FLOOR) ? FLOOR : size_i;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign mask_o[b] = (SZ_W'(b) <= msb);
  end
endmodule

// File: rtl/sp_svc_req.sv
module sp_svc_req #(
  parameter int unsigned LW    = 5,
  parameter int unsigned TW    = 4,
  parameter bit          IS_TX = 1'b0
) (
  input  logic [LW-1:0]     level_i,
  input  logic [TW-1:0]     thr_i,
  input  logic              irq_en_i,
  input  logic              dma_en_i,
  output logic              trig_o,
  output sp_pkg::svc_req_t  req_o
);
  logic [LW:0] lv, th;
  assign lv = {1'b0, level_i};
  assign th = (LW + 1)'(thr_i);

  if (IS_TX) begin : g_tx
    // refill request: level at most threshold plus one
    assign trig_o = (lv <= th + 1'b1);
  end else begin : g_rx
    // drain request: level strictly above threshold
    assign trig_o = (lv > th);
  end

  assign req_o.irq = trig_o & irq_en_i;
  assign req_o.dma = trig_o & dma_en_i;
endmodule

// File: rtl/sp_fifo_if.sv
module sp_fifo_if #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned THR_W = 4,
  parameter int unsigned SZ_W  = $clog2(DW),
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [SZ_W-1:0]  dsize_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic             rx_irq_en_i,
  input  logic             rx_dma_en_i,
  input  logic             tx_irq_en_i,
  input  logic             tx_dma_en_i,
  input  logic             ovr_clr_i,
  input  logic             unr_clr_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_rd_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [DW-1:0]    tx_data_o,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  input  logic [DW-1:0]    rx_data_i,
  output logic [LW-1:0]    rx_level_o,
  output logic [LW-1:0]    tx_level_o,
  output logic             rx_trig_o,
  output logic             tx_trig_o,
  output logic             rx_irq_o,
  output logic             rx_dma_o,
  output logic             tx_irq_o,
  output logic             tx_dma_o,
  output logic             tx_ovr_o,
  output logic             rx_unr_o
);
  import sp_pkg::*;

  logic [DW-1:0] mask, tx_head, rx_head;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_ovr_q, rx_unr_q;
  svc_req_t      rx_req, tx_req;

  sp_size_mask #(.DW(DW), .SZ_W(SZ_W)) u_mask (
    .size_i (dsize_i),
    .mask_o (mask)
  );

  sp_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (bus_wr_i),
    .din_i   (bus_wdata_i),
    .pop_i   (tx_ready_i),
    .dout_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .level_o (tx_level_o)
  );

  sp_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (rx_valid_i),
    .din_i   (rx_data_i & mask),
    .pop_i   (bus_rd_i),
    .dout_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .level_o (rx_level_o)
  );

  sp_svc_req #(.LW(LW), .TW(THR_W), .IS_TX(1'b0)) u_rx_req (
    .level_i  (rx_level_o),
    .thr_i    (rx_thr_i),
    .irq_en_i (rx_irq_en_i),
    .dma_en_i (rx_dma_en_i),
    .trig_o   (rx_trig_o),
    .req_o    (rx_req)
  );

  sp_svc_req #(.LW(LW), .TW(THR_W), .IS_TX(1'b1)) u_tx_req (
    .level_i  (tx_level_o),
    .thr_i    (tx_thr_i),
    .irq_en_i (tx_irq_en_i),
    .dma_en_i (tx_dma_en_i),
    .trig_o   (tx_trig_o),
    .req_o    (tx_req)
  );

  // sticky flags, new event wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovr_q <= 1'b0;
      rx_unr_q <= 1'b0;
    end else begin
      if (bus_wr_i && tx_full) tx_ovr_q <= 1'b1;
      else if (ovr_clr_i)      tx_ovr_q <= 1'b0;
      if (bus_rd_i && rx_empty) rx_unr_q <= 1'b1;
      else if (unr_clr_i)       rx_unr_q <= 1'b0;
    end
  end

  assign bus_rdata_o = rx_empty ? '0 : rx_head;
  assign tx_valid_o  = ~tx_empty;
  assign tx_data_o   = tx_head & mask;
  assign rx_ready_o  = ~rx_full;
  assign rx_irq_o    = rx_req.irq;
  assign rx_dma_o    = rx_req.dma;
  assign tx_irq_o    = tx_req.irq;
  assign tx_dma_o    = tx_req.dma;
  assign tx_ovr_o    = tx_ovr_q;
  assign rx_unr_o    = rx_unr_q;
endmodule

// File: rtl/sp_fifo_if_chk.sv
module sp_fifo_if_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SZ_W  = $clog2(DW),
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            flush_i,
  input logic [SZ_W-1:0] dsize_i,
  input logic            bus_wr_i,
  input logic            bus_rd_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic            tx_valid_o,
  input logic            tx_ready_i,
  input logic [DW-1:0]   tx_data_o,
  input logic            rx_ready_o,
  input logic [LW-1:0]   rx_level_o,
  input logic [LW-1:0]   tx_level_o,
  input logic            tx_ovr_o,
  input logic            rx_unr_o
);
  localparam logic [LW-1:0] FULL_LV = LW'(DEPTH);

  logic [DW:0]   wide;
  logic [DW-1:0] ref_mask;
  int unsigned   nbits;

  always_comb begin
    nbits    = (int'(dsize_i) < 3) ? 4 : int'(dsize_i) + 1;
    wide     = ((DW + 1)'(1) << nbits) - 1'b1;
    ref_mask = wide[DW-1:0];
  end

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && tx_level_o != FULL_LV && !tx_ready_i && !flush_i
      |=> tx_level_o == $past(tx_level_o) + 1'b1);

  a_r4_tx_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_data_o & ~ref_mask) == '0);

  a_r8_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && tx_level_o == FULL_LV |=> tx_ovr_o);

  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && tx_level_o == FULL_LV && !(tx_valid_o && tx_ready_i) && !flush_i
      |=> tx_level_o == FULL_LV);

  a_r9_unr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && rx_level_o == '0 |=> rx_unr_o);

  a_r9_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o == '0 |-> bus_rdata_o == '0);

  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> rx_level_o == '0 && tx_level_o == '0);

  a_r11_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o == (rx_level_o != FULL_LV));

  a_r12_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o <= FULL_LV && tx_level_o <= FULL_LV);
endmodule

bind sp_fifo_if sp_fifo_if_chk #(.DW(DW), .DEPTH(DEPTH), .SZ_W(SZ_W), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .dsize_i     (dsize_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_data_o   (tx_data_o),
  .rx_ready_o  (rx_ready_o),
  .rx_level_o  (rx_level_o),
  .tx_level_o  (tx_level_o),
  .tx_ovr_o    (tx_ovr_o),
  .rx_unr_o    (rx_unr_o)
);

// File: tb/sp_fifo_if_tb.sv
module sp_fifo_if_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 0;
  logic [4:0]  dsize_i = 5'd7;
  logic [3:0]  rx_thr_i = 0, tx_thr_i = 0;
  logic        rx_irq_en_i = 1, rx_dma_en_i = 0, tx_irq_en_i = 1, tx_dma_en_i = 0;
  logic        ovr_clr_i = 0, unr_clr_i = 0;
  logic        bus_wr_i = 0, bus_rd_i = 0;
  logic [31:0] bus_wdata_i = 0, bus_rdata_o;
  logic        tx_valid_o, tx_ready_i = 0;
  logic [31:0] tx_data_o;
  logic        rx_valid_i = 0, rx_ready_o;
  logic [31:0] rx_data_i = 0;
  logic [4:0]  rx_level_o, tx_level_o;
  logic        rx_trig_o, tx_trig_o, rx_irq_o, rx_dma_o, tx_irq_o, tx_dma_o;
  logic        tx_ovr_o, rx_unr_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];

  always #4 clk_i = ~clk_i;

  sp_fifo_if u_dut (.*);

  function automatic logic [31:0] ref_mask(input logic [4:0] ds);
    logic [32:0] w;
    int n;
    n = (ds < 3) ? 4 : int'(ds) + 1;
    w = (33'd1 << n) - 33'd1;
    return w[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  task automatic bus_write(input logic [31:0] d, input bit accept);
    bus_wr_i = 1; bus_wdata_i = d;
    if (accept) tx_q.push_back(d & ref_mask(dsize_i));
    step();
    bus_wr_i = 0;
  endtask

  task automatic bus_read(input string tag);
    logic [31:0] e;
    bus_rd_i = 1;
    @(negedge clk_i);
    e = (rx_q.size() != 0) ? rx_q.pop_front() : 32'h0;
    chk(bus_rdata_o == e, tag, bus_rdata_o, e);
    step();
    bus_rd_i = 0;
  endtask

  task automatic shift_in(input logic [31:0] d, input bit accept);
    rx_valid_i = 1; rx_data_i = d;
    if (accept) rx_q.push_back(d & ref_mask(dsize_i));
    step();
    rx_valid_i = 0;
  endtask

  // monitor: transmit words taken by the shifter
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (tx_q.size() == 0) chk(1'b0, "R2 unexpected tx word", tx_data_o, 32'h0);
      else begin
        logic [31:0] e;
        e = tx_q.pop_front();
        chk(tx_data_o == e, "R2/R4 tx word", tx_data_o, e);
      end
    end
  end

  task automatic drain_tx();
    tx_ready_i = 1;
    while (tx_level_o != 0) step();
    step();
    tx_ready_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    step();
    // R1 reset state
    chk(rx_level_o == 0 && tx_level_o == 0, "R1 levels", {rx_level_o, tx_level_o}, 0);
    chk(!tx_ovr_o && !rx_unr_o, "R1 flags", {tx_ovr_o, rx_unr_o}, 0);
    chk(!tx_valid_o, "R1 tx_valid", tx_valid_o, 0);
    chk(!rx_trig_o && tx_trig_o && tx_irq_o, "R1 triggers", {rx_trig_o, tx_trig_o, tx_irq_o}, 3'b011);

    // R7 boundary, R2 order, R4 8-bit mask
    dsize_i = 5'd7; tx_thr_i = 4'd1;
    bus_write(32'hAAAA_1234, 1);
    bus_write(32'h5555_56F0, 1);
    chk(tx_level_o == 2 && tx_trig_o && tx_irq_o && !tx_dma_o, "R7 level2 fires",
        {tx_level_o, tx_trig_o, tx_irq_o, tx_dma_o}, {5'd2, 3'b110});
    bus_write(32'h0000_0199, 1);
    chk(tx_level_o == 3, "R12 tx level 3", tx_level_o, 3);
    chk(!tx_trig_o && !tx_irq_o, "R7 level3 quiet", {tx_trig_o, tx_irq_o}, 0);
    tx_dma_en_i = 1; #1;
    chk(!tx_dma_o, "R7 dma follows trig", tx_dma_o, 0);
    drain_tx();
    chk(tx_level_o == 0 && tx_dma_o, "R7 drained dma", {tx_level_o, tx_dma_o}, 1);
    tx_dma_en_i = 0;

    // R6 boundary, R3 order, R5 12-bit mask
    dsize_i = 5'd11; rx_thr_i = 4'd3; rx_dma_en_i = 1;
    shift_in(32'hDEAD_BEEF, 1);
    shift_in(32'h1234_5678, 1);
    shift_in(32'hFFFF_FFFF, 1);
    chk(rx_level_o == 3 && !rx_trig_o && !rx_irq_o && !rx_dma_o, "R6 level3 quiet",
        {rx_level_o, rx_trig_o, rx_irq_o, rx_dma_o}, {5'd3, 3'b000});
    shift_in(32'h0000_0ABC, 1);
    chk(rx_trig_o && rx_irq_o && rx_dma_o, "R6 level4 fires", {rx_trig_o, rx_irq_o, rx_dma_o}, 3'b111);
    rx_dma_en_i = 0; #1;
    chk(!rx_dma_o && rx_irq_o, "R6 dma enable", {rx_dma_o, rx_irq_o}, 2'b01);
    dsize_i = 5'd31;  // stored words keep their arrival mask (R5)
    for (int i = 0; i < 4; i++) bus_read("R3/R5 rx word");
    chk(rx_level_o == 0, "R12 rx level 0", rx_level_o, 0);

    // R9 underrun
    bus_read("R9 empty read zero");
    chk(rx_unr_o, "R9 flag set", rx_unr_o, 1);
    step();
    chk(rx_unr_o, "R9 flag sticky", rx_unr_o, 1);
    unr_clr_i = 1; step(); unr_clr_i = 0;
    chk(!rx_unr_o, "R9 flag cleared", rx_unr_o, 0);

    // R8 overrun, full 32-bit words
    dsize_i = 5'd31;
    for (int i = 0; i < 16; i++) bus_write(32'hC000_0000 + i, 1);
    chk(tx_level_o == 16 && !tx_ovr_o, "R8 full no flag", {tx_level_o, tx_ovr_o}, {5'd16, 1'b0});
    bus_write(32'hBAD0_BAD0, 0);
    chk(tx_level_o == 16 && tx_ovr_o, "R8 drop and flag", {tx_level_o, tx_ovr_o}, {5'd16, 1'b1});
    bus_wr_i = 1; ovr_clr_i = 1; bus_wdata_i = 32'hBAD1_BAD1; step();
    bus_wr_i = 0; ovr_clr_i = 0;
    chk(tx_ovr_o, "R8 set beats clear", tx_ovr_o, 1);
    ovr_clr_i = 1; step(); ovr_clr_i = 0;
    chk(!tx_ovr_o, "R8 flag cleared", tx_ovr_o, 0);
    drain_tx();
    chk(tx_q.size() == 0, "R8 all 16 delivered", tx_q.size(), 0);

    // R11 receive full, R10 flush
    for (int i = 0; i < 16; i++) shift_in(32'h7000_0000 + i, 1);
    chk(rx_level_o == 16 && !rx_ready_o, "R11 rx full", {rx_level_o, rx_ready_o}, {5'd16, 1'b0});
    shift_in(32'h0BAD_0BAD, 0);
    chk(rx_level_o == 16, "R11 extra dropped", rx_level_o, 16);
    bus_read("R11 oldest kept");
    bus_write(32'h1111_1111, 0);
    bus_wr_i = 1; flush_i = 1; bus_wdata_i = 32'h2222_2222; step();
    bus_wr_i = 0; flush_i = 0;
    rx_q.delete();
    chk(rx_level_o == 0 && tx_level_o == 0, "R10 flush empties", {rx_level_o, tx_level_o}, 0);
    chk(bus_rdata_o == 0 && !tx_valid_o, "R10 nothing left", bus_rdata_o, 0);

    // R4 floor at 4 bits and edge sizes
    tx_ready_i = 1;
    dsize_i = 5'd0; bus_write(32'hFFFF_FFFF, 1); step(); step();
    dsize_i = 5'd2; bus_write(32'hFFFF_FFFF, 1); step(); step();
    dsize_i = 5'd3; bus_write(32'hFFFF_FFF7, 1); step(); step();
    dsize_i = 5'd4; bus_write(32'hFFFF_FFFF, 1); step(); step();
    tx_ready_i = 0;
    chk(tx_q.size() == 0, "R4 mask words delivered", tx_q.size(), 0);
    dsize_i = 5'd0; shift_in(32'hFFFF_FFFE, 1);
    bus_read("R5 4-bit rx floor");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule